// File: doc/BRIEF.md
# Selectable-Source Base Timer

This block keeps time with one 14-bit counter that runs freely and never stops on its own. The counter advances by one on each tick of a source chosen by a select input: the 32.768 kHz crystal tick, a system-clock tick, or the prescaler tick of the general-purpose timer. A fourth select code stops the count. All three sources are single-cycle enable pulses in the one system clock domain. They are not separate clocks.

The counter raises two sticky interrupt flags:

- **Long flag.** It sets on every full wrap of the counter. With the crystal source that is once every 16384 ticks, or half a second.
- **Short flag.** It sets each time the low part of the counter rolls over. A tap select sets the length of that low part, giving a period of 32, 128, 512 or 2048 ticks. With the crystal source these periods are about 0.98 ms, 3.9 ms, 15.6 ms and 62.5 ms.

Software clears each flag with its own strobe. Changing the source or the tap on the fly does not restart the count.

Top module: `base_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter returns to zero and both flags return to 0. The reset is synchronous and active low.
- R2: `long_flag_o` sets at the clock edge of the selected tick that moves the counter from 16383 to 0. It therefore sets once every 16384 selected ticks.
- R3: `short_flag_o` sets at the clock edge of the selected tick that rolls the low bits of the counter over to zero. The number of low bits depends on `tap_sel_i`: 0 gives 5 bits (32 ticks), 1 gives 7 bits (128), 2 gives 9 bits (512) and 3 gives 11 bits (2048).
- R4: `src_sel_i` chooses the tick that advances the counter: 0 selects `xtal_tick_i`, 1 selects `sys_tick_i`, 2 selects `pre_tick_i`, and 3 selects no tick, so the counter holds. Pulses on the inputs that are not selected have no effect.
- R5: A flag stays at 1 until its own clear strobe (`clr_long_i` or `clr_short_i`) is high at a clock edge. The strobe drives the flag to 0 from the next cycle, and a strobe never affects the other flag.
- R6: If a flag's set condition and its clear strobe occur at the same edge, the flag is 1 after that edge.
- R7: Changing `src_sel_i` or `tap_sel_i` never resets the counter. The count continues from its present value, so the next short flag follows the new tap's rollover of that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick_i | input | 1 | One-cycle pulse at the 32.768 kHz crystal rate |
| sys_tick_i | input | 1 | One-cycle system-clock tick |
| pre_tick_i | input | 1 | One-cycle pulse from the general timer's prescaler |
| src_sel_i | input | 2 | Tick source: 0 crystal, 1 system, 2 prescaler, 3 off |
| tap_sel_i | input | 2 | Short period: 0/1/2/3 = 32/128/512/2048 ticks |
| clr_long_i | input | 1 | Clear strobe for the long flag |
| clr_short_i | input | 1 | Clear strobe for the short flag |
| long_flag_o | output | 1 | Sticky flag for a full 14-bit wrap |
| short_flag_o | output | 1 | Sticky flag for the tapped short period |

## Verification
The in-line properties check, on every cycle:

- that the counter holds when no tick is selected, and that it steps from its maximum back to zero;
- that select code 3 yields no tick;
- that each flag is held, set or cleared correctly, including a set winning over a clear.

Only the bench scenarios can show the periods themselves, counted at the ports:

- the 32 to 2048 tick short periods and the 16384 tick wrap;
- that pulses on unselected sources are ignored;
- that a tap change part-way through a count keeps the accumulated value.

A reference model in the bench predicts both flags cycle by cycle for these scenarios.

// File: rtl/btmr_pkg.sv
// Package: shared encodings for the base timer.
// Assumes the select ports are two bits wide.
package btmr_pkg;
    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_OFF  = 2'd3
    } src_sel_t;
endpackage

// File: rtl/btmr_src_mux.sv
// btmr_src_mux: picks one of three tick enables by the source select.
// Assumes every tick input is a one-cycle pulse in the clk domain.
module btmr_src_mux
    import btmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_tick_i,
    input  logic       sys_tick_i,
    input  logic       pre_tick_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    src_sel_t sel;
    assign sel = src_sel_t'(sel_i);

    // Route the chosen enable; the off code yields no tick.
    always_comb begin
        case (sel)
            SRC_XTAL: tick_o = xtal_tick_i;
            SRC_SYS:  tick_o = sys_tick_i;
            SRC_PRE:  tick_o = pre_tick_i;
            default:  tick_o = 1'b0;
        endcase
    end

    // R4
    off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd3) |-> !tick_o);
endmodule

// File: rtl/btmr_count.sv
// btmr_count: free-running counter with a full-wrap pulse and tapped
// rollover pulses. A tick enable advances it; tap select picks the
// low-bit field whose rollover makes the short pulse.
// Assumes TAP_BASE + (2**TAP_SEL_W - 1) * TAP_STEP <= CNT_W.
module btmr_count #(
    parameter int CNT_W     = 14,
    parameter int TAP_SEL_W = 2,
    parameter int TAP_BASE  = 5,
    parameter int TAP_STEP  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [TAP_SEL_W-1:0] tap_sel_i,
    output logic                 wrap_o,
    output logic                 tap_o
);
    localparam int NTAPS = 2 ** TAP_SEL_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [NTAPS-1:0] tap_hit;

    // Advance on each tick; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (tick_i) count_q <= count_q + 1'b1;
    end

    // Detect, for each tap length, that the low field is all ones.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        localparam int LEN = TAP_BASE + k * TAP_STEP;
        localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << LEN) - 64'd1);
        assign tap_hit[k] = &(count_q | ~MASK);
    end

    // Pulses fire on the tick that causes the rollover.
    assign wrap_o = tick_i && (count_q == CNT_MAX);
    assign tap_o  = tick_i && tap_hit[tap_sel_i];

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_q));
    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_q == CNT_MAX) |=> (count_q == '0));
endmodule

// File: rtl/btmr_flag.sv
// btmr_flag: sticky flag; a set beats a clear in the same cycle.
// Assumes set and clear are single-cycle strobes in clk.
module btmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R5
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/base_timer.sv
// base_timer: 14-bit base timer with selectable tick source, a full-wrap
// flag and a tapped short-period flag.
// Assumes all tick inputs and clear strobes are synchronous to clk.
module base_timer #(
    parameter int CNT_W     = 14,
    parameter int TAP_SEL_W = 2,
    parameter int TAP_BASE  = 5,
    parameter int TAP_STEP  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xtal_tick_i,
    input  logic                 sys_tick_i,
    input  logic                 pre_tick_i,
    input  logic [1:0]           src_sel_i,
    input  logic [TAP_SEL_W-1:0] tap_sel_i,
    input  logic                 clr_long_i,
    input  logic                 clr_short_i,
    output logic                 long_flag_o,
    output logic                 short_flag_o
);
    logic tick, wrap, tap;

    btmr_src_mux u_mux (
        .clk(clk), .rst_n(rst_n),
        .xtal_tick_i(xtal_tick_i), .sys_tick_i(sys_tick_i),
        .pre_tick_i(pre_tick_i), .sel_i(src_sel_i), .tick_o(tick)
    );

    btmr_count #(
        .CNT_W(CNT_W), .TAP_SEL_W(TAP_SEL_W),
        .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tap_sel_i(tap_sel_i),
        .wrap_o(wrap), .tap_o(tap)
    );

    btmr_flag u_long (
        .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(clr_long_i),
        .flag_o(long_flag_o)
    );

    btmr_flag u_short (
        .clk(clk), .rst_n(rst_n), .set_i(tap), .clr_i(clr_short_i),
        .flag_o(short_flag_o)
    );

    // R2
    long_implies_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> short_flag_o);
endmodule

// File: tb/tb_base_timer.sv
// Scoreboard bench: the driver task predicts the flags from the
// requirements and queues them; the monitor compares after each edge.
module tb_base_timer;
    typedef struct {
        logic  l;
        logic  s;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xt = 1'b0, sy = 1'b0, pr = 1'b0;
    logic [1:0] src = 2'd0, tap = 2'd0;
    logic cl = 1'b0, cs = 1'b0;
    logic long_f, short_f;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;
    exp_t q[$];

    // model state
    int m_cnt = 0;
    logic m_l = 1'b0, m_s = 1'b0;

    base_timer dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick_i(xt), .sys_tick_i(sy),
        .pre_tick_i(pr), .src_sel_i(src), .tap_sel_i(tap),
        .clr_long_i(cl), .clr_short_i(cs),
        .long_flag_o(long_f), .short_flag_o(short_f)
    );

    always #10 clk = ~clk;

    // Drive one cycle of inputs and queue the expected flags.
    task automatic step(input logic r, input logic x, input logic y,
                        input logic p, input logic [1:0] sel,
                        input logic [1:0] tp, input logic c_l,
                        input logic c_s, input string tag);
        logic tk, set_l, set_s;
        int per;
        exp_t e;
        @(negedge clk);
        rst_n = r; xt = x; sy = y; pr = p; src = sel; tap = tp;
        cl = c_l; cs = c_s;
        tk = (sel == 2'd0) ? x : (sel == 2'd1) ? y : (sel == 2'd2) ? p : 1'b0;
        per = 32 << (2 * int'(tp));
        if (!r) begin
            m_cnt = 0; m_l = 1'b0; m_s = 1'b0;
        end else begin
            set_s = tk && ((m_cnt % per) == per - 1);
            set_l = tk && (m_cnt == 16383);
            if (tk) m_cnt = (m_cnt + 1) % 16384;
            m_s = set_s ? 1'b1 : (c_s ? 1'b0 : m_s);
            m_l = set_l ? 1'b1 : (c_l ? 1'b0 : m_l);
        end
        e.l = m_l; e.s = m_s; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (long_f !== e.l || short_f !== e.s) begin
                    fails++;
                    $display("FAIL %s: long=%b short=%b expected long=%b short=%b",
                             e.tag, long_f, short_f, e.l, e.s);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with tick activity present
        for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 2'd1, 2'd0, 0, 0, "R1");
        // R3: crystal source, tap 0, other sources noisy (R4)
        for (int i = 0; i < 300; i++)
            step(1, (i % 3) == 0, 1, 1, 2'd0, 2'd0, 0, m_s && (i % 7 == 0), "R3");
        // R5: clear short flag, check it stays clear without ticks
        step(1, 0, 0, 0, 2'd0, 2'd0, 0, 1, "R5");
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 2'd3, 2'd0, 0, 0, "R5");
        // R4: off code, all tick inputs active, counter holds
        for (int i = 0; i < 200; i++) step(1, 1, 1, 1, 2'd3, 2'd0, 0, 0, "R4");
        // R4: prescaler source with tap 1
        for (int i = 0; i < 600; i++)
            step(1, 1, 1, (i % 2) == 0, 2'd2, 2'd1, 0, m_s, "R4");
        // R6: clear held high while ticking on tap 0
        for (int i = 0; i < 100; i++) step(1, 0, 1, 0, 2'd1, 2'd0, 0, 1, "R6");
        // R7: tap change mid-count without reset
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 2'd0, 2'd2, 0, 0, "R7");
        for (int i = 0; i < 1500; i++)
            step(1, 1, 0, 0, 2'd0, 2'd1, 0, m_s, "R7");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 1, 2'd2, 2'd2, 0, m_s, "R7");
        // R2: system tick every cycle, tap 3, full wraps
        for (int i = 0; i < 34000; i++)
            step(1, 0, 1, 0, 2'd1, 2'd3, m_l && (i % 5 == 0), m_s, "R2");
        // R1: reset mid-run clears flags
        step(0, 0, 1, 0, 2'd1, 2'd3, 0, 0, "R1");
        step(1, 0, 0, 0, 2'd1, 2'd3, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule